// File: doc/BRIEF.md
# Serial Port Register and Status Controller

This block is the software-facing register file of a serial port. A host reaches it over a simple single-cycle register bus, which carries an address, a write strobe, a read strobe, write data and combinational read data. It holds a status word, a receive data holding register, and five configuration words: a baud divisor, three control words and a guard-time word. Of these, only the first control word has any effect inside the block. The baud and guard-time words are stored for the line logic next to this block.

Received bytes arrive from a byte-stream source over a valid/ready handshake. A byte is kept only while both the port-enable and receive-enable bits are on. Writing the data register emits one byte to the transmit side as a single-cycle valid pulse, with no backpressure. One level-sensitive interrupt line goes high whenever a flagged status event has its matching enable bit set.

Status flags follow these rules. A write of a small value to the status register replaces it. A write of a large value masks it with AND. The transmit-empty flag is set on every replacing write. The transmit-complete flag is set by each accepted transmit. Reading the data register pops the receive flag.

Top module: `serial_ctrl_regs`

## Requirements
- R1: `irq` is high exactly when, for at least one of status bits 5 (receive full), 6 (transmit complete) and 7 (transmit empty), both that status bit and the same bit of control word 1 are 1.
- R2: A byte offered while control word 1 bit 13 (port enable) or bit 2 (receive enable) is 0 is consumed and dropped. The data register and the status register do not change.
- R3: `rx_ready` equals the inverse of status bit 5. An accepted byte is loaded into the data register and sets status bit 5 at the next clock edge.
- R4: A read of offset 0x04 returns the held byte, zero-extended, with only the low 10 bits able to be nonzero. From the next edge, status bit 5 is 0.
- R5: A write to offset 0x00 with a value of at most 0x3FF replaces the status with that value, with bit 7 forced to 1.
- R6: A write to offset 0x00 with a value above 0x3FF leaves the status equal to its old value ANDed with the low 10 bits of the written value.
- R7: A write to offset 0x04 with a value below 0xF000 drives `tx_valid` high for exactly the one cycle after the write edge, with `tx_data` equal to the low byte of the value. The same write sets status bit 6.
- R8: A write to offset 0x04 with a value of 0xF000 or more produces no transmit pulse and leaves the status unchanged.
- R9: Offsets 0x08 (baud), 0x0C (control 1), 0x10 (control 2), 0x14 (control 3) and 0x18 (guard time) read back the full 32-bit value last written.
- R10: After reset the status reads 0xC0, every other register reads 0, `irq` is low and `tx_valid` is low.
- R11: Within the 0x400-byte window, a read of any other offset (for example 0x1C, 0x3FC or a misaligned 0x05) returns 0, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| bus_addr | input | 10 | Byte offset within the register window |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe; enables read side effects |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| rx_valid | input | 1 | Receive source offers a byte |
| rx_data | input | 8 | Offered byte |
| rx_ready | output | 1 | Block can take a byte |
| tx_valid | output | 1 | One-cycle transmit pulse |
| tx_data | output | 8 | Transmitted byte |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default parameters: a 10-bit offset, 32-bit data, a 10-bit status word, and the 0x3FF and 0xF000 write thresholds. These values put both sides of each threshold within reach of directed writes. They also allow an unmapped offset at the far end of the window to be probed. The bench moves the interrupt through each of its three sources, and gates reception on each enable bit in turn. It also offers a byte while the holding register is still full, to show that the byte is refused.

// File: rtl/serial_ctrl_regs_pkg.sv
package serial_ctrl_regs_pkg;

  // Status bit positions (shared with the control-word enable bits)
  localparam int unsigned ST_RXFULL_BIT = 5;
  localparam int unsigned ST_TXDONE_BIT = 6;
  localparam int unsigned ST_TXEMPTY_BIT = 7;

  // Control word 1 gating bits
  localparam int unsigned C1_RXEN_BIT = 2;
  localparam int unsigned C1_PORTEN_BIT = 13;

  localparam int unsigned ST_RESET_VAL = 32'h0000_00C0;

  // Byte offsets inside the window
  localparam int unsigned OFF_STATUS = 'h00;
  localparam int unsigned OFF_DATA = 'h04;
  localparam int unsigned OFF_BAUD = 'h08;
  localparam int unsigned OFF_CTL1 = 'h0C;
  localparam int unsigned OFF_CTL2 = 'h10;
  localparam int unsigned OFF_CTL3 = 'h14;
  localparam int unsigned OFF_GUARD = 'h18;

  // Index of each stored configuration word
  typedef enum logic [2:0] {
    CFG_BAUD = 3'd0,
    CFG_CTL1 = 3'd1,
    CFG_CTL2 = 3'd2,
    CFG_CTL3 = 3'd3,
    CFG_GUARD = 3'd4
  } cfg_idx_e;

  localparam int unsigned NUM_CFG = 5;

endpackage

// File: rtl/ser_cfg_bank.sv
module ser_cfg_bank
  import serial_ctrl_regs_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_CFG-1:0]              cfg_we,
  input  logic [DATA_W-1:0]               wdata,
  output logic [NUM_CFG-1:0][DATA_W-1:0]  cfg_q
);

  for (genvar gi = 0; gi < NUM_CFG; gi++) begin : g_word
    logic [DATA_W-1:0] word_d;

    always_comb begin
      word_d = cfg_q[gi];
      if (cfg_we[gi]) word_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[gi] <= '0;
      end else if (cfg_we[gi]) begin
        cfg_q[gi] <= word_d;
      end
    end

    assert_cfg_hold_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we[gi] |=> $stable(cfg_q[gi]));
  end

endmodule

// File: rtl/ser_status_unit.sv
module ser_status_unit
  import serial_ctrl_regs_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned SR_W     = 10,
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned TX_LIMIT = 32'h0000_F000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sr_we,
  input  logic              dr_we,
  input  logic              dr_pop,
  input  logic [DATA_W-1:0] wdata,
  input  logic              port_en,
  input  logic              rx_en,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rx_ready,
  output logic [SR_W-1:0]   sr_q,
  output logic [BYTE_W-1:0] dr_q,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data
);

  localparam logic [DATA_W-1:0] REPLACE_MAX = DATA_W'((2 ** SR_W) - 1);
  localparam logic [DATA_W-1:0] TX_LIM_W    = DATA_W'(TX_LIMIT);
  localparam logic [SR_W-1:0]   SR_RST      = SR_W'(ST_RESET_VAL);

  logic              rx_take;
  logic              rx_load;
  logic              sr_small;
  logic              tx_fire;
  logic [SR_W-1:0]   sr_d;
  logic [BYTE_W-1:0] dr_d;
  logic [BYTE_W-1:0] tx_data_d;
  logic              sr_en;

  assign rx_ready = ~sr_q[ST_RXFULL_BIT];
  assign rx_take  = rx_valid & rx_ready;
  assign rx_load  = rx_take & port_en & rx_en;
  assign sr_small = (wdata <= REPLACE_MAX);
  assign tx_fire  = dr_we & (wdata < TX_LIM_W);

  always_comb begin
    sr_d = sr_q;
    if (sr_we) begin
      if (sr_small) begin
        sr_d = wdata[SR_W-1:0];
        sr_d[ST_TXEMPTY_BIT] = 1'b1;
      end else begin
        sr_d = sr_q & wdata[SR_W-1:0];
      end
    end
    if (dr_pop)  sr_d[ST_RXFULL_BIT] = 1'b0;
    if (tx_fire) sr_d[ST_TXDONE_BIT] = 1'b1;
    if (rx_load) sr_d[ST_RXFULL_BIT] = 1'b1;
  end

  assign sr_en     = sr_we | dr_pop | tx_fire | rx_load;
  assign dr_d      = rx_load ? rx_data : dr_q;
  assign tx_data_d = tx_fire ? wdata[BYTE_W-1:0] : tx_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= SR_RST;
    end else if (sr_en) begin
      sr_q <= sr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dr_q <= '0;
    end else if (rx_load) begin
      dr_q <= dr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      tx_valid <= tx_fire;
      if (tx_fire) tx_data <= tx_data_d;
    end
  end

  assert_drop_keeps_data_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && !(port_en && rx_en)) |=> $stable(dr_q));

  assert_accept_sets_full_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && port_en && rx_en) |=> (sr_q[ST_RXFULL_BIT] && !rx_ready));

  assert_pop_clears_full_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    (dr_pop && !(rx_valid && rx_ready) && !sr_we) |=> !sr_q[ST_RXFULL_BIT]);

  assert_small_write_txempty_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    (sr_we && (wdata <= REPLACE_MAX)) |=> sr_q[ST_TXEMPTY_BIT]);

  assert_tx_pulse_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    (dr_we && (wdata < TX_LIM_W)) |=> (tx_valid && sr_q[ST_TXDONE_BIT]));

  assert_tx_big_ignored_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    (dr_we && !(wdata < TX_LIM_W)) |=> !tx_valid);

endmodule

// File: rtl/ser_irq_gen.sv
module ser_irq_gen
  import serial_ctrl_regs_pkg::*;
#(
  parameter int unsigned SR_W = 10
) (
  input  logic [SR_W-1:0] sr_q,
  input  logic [SR_W-1:0] ctl_en,
  output logic            irq
);

  localparam logic [SR_W-1:0] SRC_MASK =
      (SR_W'(1) << ST_RXFULL_BIT) | (SR_W'(1) << ST_TXDONE_BIT) | (SR_W'(1) << ST_TXEMPTY_BIT);

  assign irq = |(sr_q & ctl_en & SRC_MASK);

endmodule

// File: rtl/serial_ctrl_regs.sv
module serial_ctrl_regs
  import serial_ctrl_regs_pkg::*;
#(
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned SR_W      = 10,
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned RD_KEEP_W = 10,
  parameter int unsigned TX_LIMIT  = 32'h0000_F000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  output logic              irq
);

  localparam logic [DATA_W-1:0] RD_MASK = DATA_W'((64'd1 << RD_KEEP_W) - 64'd1);

  logic                           hit_sr, hit_dr;
  logic [NUM_CFG-1:0]             cfg_hit;
  logic [NUM_CFG-1:0]             cfg_we;
  logic [NUM_CFG-1:0][DATA_W-1:0] cfg_q;
  logic [SR_W-1:0]                sr_q;
  logic [BYTE_W-1:0]              dr_q;
  logic [DATA_W-1:0]              ctl1;

  assign hit_sr = (bus_addr == ADDR_W'(OFF_STATUS));
  assign hit_dr = (bus_addr == ADDR_W'(OFF_DATA));

  assign cfg_hit[CFG_BAUD]  = (bus_addr == ADDR_W'(OFF_BAUD));
  assign cfg_hit[CFG_CTL1]  = (bus_addr == ADDR_W'(OFF_CTL1));
  assign cfg_hit[CFG_CTL2]  = (bus_addr == ADDR_W'(OFF_CTL2));
  assign cfg_hit[CFG_CTL3]  = (bus_addr == ADDR_W'(OFF_CTL3));
  assign cfg_hit[CFG_GUARD] = (bus_addr == ADDR_W'(OFF_GUARD));
  assign cfg_we = cfg_hit & {NUM_CFG{bus_we}};
  assign ctl1   = cfg_q[CFG_CTL1];

  ser_cfg_bank #(.DATA_W(DATA_W)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .cfg_we (cfg_we),
    .wdata  (bus_wdata),
    .cfg_q  (cfg_q)
  );

  ser_status_unit #(
    .DATA_W   (DATA_W),
    .SR_W     (SR_W),
    .BYTE_W   (BYTE_W),
    .TX_LIMIT (TX_LIMIT)
  ) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .sr_we    (bus_we & hit_sr),
    .dr_we    (bus_we & hit_dr),
    .dr_pop   (bus_re & hit_dr),
    .wdata    (bus_wdata),
    .port_en  (ctl1[C1_PORTEN_BIT]),
    .rx_en    (ctl1[C1_RXEN_BIT]),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .rx_ready (rx_ready),
    .sr_q     (sr_q),
    .dr_q     (dr_q),
    .tx_valid (tx_valid),
    .tx_data  (tx_data)
  );

  ser_irq_gen #(.SR_W(SR_W)) u_irq (
    .sr_q   (sr_q),
    .ctl_en (ctl1[SR_W-1:0]),
    .irq    (irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (hit_sr) bus_rdata = DATA_W'(sr_q);
    if (hit_dr) bus_rdata = DATA_W'(dr_q) & RD_MASK;
    for (int k = 0; k < NUM_CFG; k++) begin
      if (cfg_hit[k]) bus_rdata = cfg_q[k];
    end
  end

  assert_irq_quiet_R1 : assert property (@(posedge clk) disable iff (!rst_n)
    (ctl1[ST_RXFULL_BIT] == 1'b0 && ctl1[ST_TXDONE_BIT] == 1'b0 &&
     ctl1[ST_TXEMPTY_BIT] == 1'b0) |-> !irq);

  assert_unmapped_read_zero_R11 : assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_sr && !hit_dr && cfg_hit == '0) |-> (bus_rdata == '0));

endmodule

// File: tb/serial_ctrl_regs_tb.sv
module serial_ctrl_regs_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [9:0]  bus_addr;
  logic        bus_we;
  logic        bus_re;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        rx_valid;
  logic [7:0]  rx_data;
  logic        rx_ready;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        irq;

  int n_chk;
  int n_bad;
  bit finished;
  logic        last_txv;
  logic [7:0]  last_txd;

  serial_ctrl_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Write at a falling edge; tx outputs sampled at the falling edge after the write edge.
  task automatic bus_write(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    last_txv = tx_valid;
    last_txd = tx_data;
  endtask

  task automatic bus_read(input logic [9:0] a, input bit pop, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = pop;
    #1;
    d = bus_rdata;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic rx_push(input logic [7:0] b, output logic rdy);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    #1;
    rdy = rx_ready;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    bus_read(10'h00, 0, v); chk("R10 status", v, 32'hC0);
    bus_read(10'h04, 0, v); chk("R10 data", v, 0);
    bus_read(10'h0C, 0, v); chk("R10 ctl1", v, 0);
    bus_read(10'h08, 0, v); chk("R10 baud", v, 0);
    chk("R10 irq", {31'd0, irq}, 0);
    chk("R10 tx_valid", {31'd0, tx_valid}, 0);
  endtask

  task automatic t_plain_regs;
    logic [31:0] v;
    bus_write(10'h08, 32'hDEAD_BEEF); bus_read(10'h08, 0, v); chk("R9 baud", v, 32'hDEAD_BEEF);
    bus_write(10'h10, 32'h1234_5678); bus_read(10'h10, 0, v); chk("R9 ctl2", v, 32'h1234_5678);
    bus_write(10'h14, 32'hFFFF_0001); bus_read(10'h14, 0, v); chk("R9 ctl3", v, 32'hFFFF_0001);
    bus_write(10'h18, 32'h0000_00A5); bus_read(10'h18, 0, v); chk("R9 guard", v, 32'hA5);
    bus_write(10'h0C, 32'h8000_0000); bus_read(10'h0C, 0, v); chk("R9 ctl1", v, 32'h8000_0000);
    chk("R1 no enable no irq", {31'd0, irq}, 0);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    bus_write(10'h1C, 32'hFFFF_FFFF);
    bus_write(10'h3FC, 32'hFFFF_FFFF);
    bus_write(10'h05, 32'hFFFF_FFFF);
    bus_read(10'h1C, 0, v);  chk("R11 read 0x1C", v, 0);
    bus_read(10'h3FC, 0, v); chk("R11 read 0x3FC", v, 0);
    bus_read(10'h05, 0, v);  chk("R11 read 0x05", v, 0);
    bus_read(10'h08, 0, v);  chk("R11 baud untouched", v, 32'hDEAD_BEEF);
    bus_read(10'h00, 0, v);  chk("R11 status untouched", v, 32'hC0);
  endtask

  task automatic t_status_writes;
    logic [31:0] v;
    bus_write(10'h00, 32'h0); bus_read(10'h00, 0, v); chk("R5 zero write keeps TXE", v, 32'h80);
    bus_write(10'h00, 32'h3FF); bus_read(10'h00, 0, v); chk("R5 replace 0x3FF", v, 32'h3FF);
    bus_write(10'h00, 32'hFFFF_FFBF); bus_read(10'h00, 0, v); chk("R6 AND clears bit6", v, 32'h3BF);
    bus_write(10'h00, 32'hFFFF_FF7F); bus_read(10'h00, 0, v); chk("R6 AND clears bit7", v, 32'h33F);
    bus_write(10'h00, 32'h0000_0400); bus_read(10'h00, 0, v); chk("R6 AND with 0x400", v, 32'h0);
    bus_write(10'h00, 32'h0000_0001); bus_read(10'h00, 0, v); chk("R5 replace 0x001", v, 32'h81);
  endtask

  task automatic t_tx;
    logic [31:0] v;
    bus_write(10'h04, 32'h0000_01A5);
    chk("R7 tx_valid", {31'd0, last_txv}, 1);
    chk("R7 tx_data", {24'd0, last_txd}, 32'hA5);
    @(negedge clk); #1;
    chk("R7 single pulse", {31'd0, tx_valid}, 0);
    bus_read(10'h00, 0, v); chk("R7 TC set", v, 32'hC1);
    bus_write(10'h00, 32'hFFFF_FFBF);
    bus_write(10'h04, 32'h0000_F000);
    chk("R8 no pulse", {31'd0, last_txv}, 0);
    bus_read(10'h00, 0, v); chk("R8 status unchanged", v, 32'h81);
    bus_write(10'h04, 32'h0000_EFFF);
    chk("R7 edge tx_valid", {31'd0, last_txv}, 1);
    chk("R7 edge tx_data", {24'd0, last_txd}, 32'hFF);
    bus_read(10'h00, 0, v); chk("R7 TC set again", v, 32'hC1);
  endtask

  task automatic t_rx_irq;
    logic [31:0] v;
    logic rdy;
    bus_write(10'h00, 32'h0);
    bus_write(10'h0C, 32'h0000_0080);
    chk("R1 TXE irq", {31'd0, irq}, 1);
    bus_write(10'h0C, 32'h0000_0040);
    chk("R1 TC disabled source", {31'd0, irq}, 0);
    bus_write(10'h04, 32'h11);
    chk("R1 TC irq", {31'd0, irq}, 1);
    bus_write(10'h00, 32'hFFFF_FFBF);
    chk("R1 TC cleared irq low", {31'd0, irq}, 0);
    bus_write(10'h0C, 32'h0000_2020);
    rx_push(8'h3C, rdy);
    chk("R3 ready when empty", {31'd0, rdy}, 1);
    bus_read(10'h00, 0, v); chk("R2 no receive enable drop", v, 32'h80);
    bus_read(10'h04, 0, v); chk("R2 data unchanged", v, 0);
    bus_write(10'h0C, 32'h0000_0024);
    rx_push(8'h3D, rdy);
    bus_read(10'h00, 0, v); chk("R2 no port enable drop", v, 32'h80);
    chk("R1 irq low after drops", {31'd0, irq}, 0);
    bus_write(10'h0C, 32'h0000_2024);
    rx_push(8'hE7, rdy);
    chk("R3 ready before accept", {31'd0, rdy}, 1);
    chk("R3 not ready when full", {31'd0, rx_ready}, 0);
    chk("R1 RXNE irq", {31'd0, irq}, 1);
    bus_read(10'h00, 0, v); chk("R3 full flag", v, 32'hA0);
    rx_push(8'h55, rdy);
    chk("R3 refused while full", {31'd0, rdy}, 0);
    bus_read(10'h04, 1, v); chk("R4 data read", v, 32'hE7);
    chk("R4 flag popped", {31'd0, rx_ready}, 1);
    chk("R1 irq low after pop", {31'd0, irq}, 0);
    bus_read(10'h00, 0, v); chk("R4 status after pop", v, 32'h80);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    n_chk = 0; n_bad = 0; finished = 1'b0;
    last_txv = 1'b0; last_txd = '0;
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_re = 1'b0; bus_wdata = '0;
    rx_valid = 1'b0; rx_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_plain_regs();
    t_unmapped();
    t_status_writes();
    t_tx();
    t_rx_irq();
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule